// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block buffers audio samples between a system bus and a serial audio engine. It holds one first-in first-out queue for outgoing samples and one for incoming samples. Each queue holds eight 32-bit words. On the outgoing path the bus writes words in and the serializer takes them out. On the incoming path the deserializer writes words in and the bus reads them out.

Three request outputs pace the data movers: one interrupt request and two DMA requests. Each output has its own pair of thresholds and its own pair of enables. The incoming side raises a request when its queue holds enough words. The outgoing side raises a request when its queue has drained far enough. A packed status word reports both fill levels and all three requests. Each queue has its own clear input, which empties it.

Top module: `audio_req_fifo`

## Requirements
- R1: Each queue stores up to 8 words of 32 bits and returns them in the order they were written.
- R2: The status word carries the incoming fill level in bits 12:8 and the outgoing fill level in bits 20:16. All other bits from 3 upward read 0. Both levels are 0 after reset.
- R3: A write to a queue that holds 8 words is ignored. The level stays at 8 and the stored words are not changed.
- R4: A read from an empty queue is ignored. The level stays at 0 and the read data keeps the last value read.
- R5: The incoming condition of a request source is true when its incoming enable is set and the incoming level is greater than or equal to its incoming threshold.
- R6: The outgoing condition of a request source is true when its outgoing enable is set and the outgoing level is less than or equal to its outgoing threshold.
- R7: Each request is the OR of its two enabled conditions and is recomputed in every cycle from the current levels and settings. With both enables clear the request is 0. Enable vectors are indexed 0 = interrupt, 1 = DMA request 1, 2 = DMA request 2.
- R8: Status bit 0 equals the interrupt request, bit 1 equals DMA request 1 and bit 2 equals DMA request 2.
- R9: The interrupt thresholds are 4 bits wide and the DMA thresholds are 5 bits wide.
- R10: A clear input empties only its own queue, so the level reads 0 in the next cycle. A clear takes priority over a write or read in the same cycle.
- R11: Read data is registered. A word taken by an accepted read appears on the read data port in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_tx_push | input | 1 | Bus writes a word into the outgoing queue |
| bus_tx_data | input | 32 | Word written into the outgoing queue |
| ser_tx_pop | input | 1 | Serializer takes a word from the outgoing queue |
| ser_tx_data | output | 32 | Last word taken from the outgoing queue |
| ser_rx_push | input | 1 | Deserializer writes a word into the incoming queue |
| ser_rx_data | input | 32 | Word written into the incoming queue |
| bus_rx_pop | input | 1 | Bus reads a word from the incoming queue |
| bus_rx_data | output | 32 | Last word read from the incoming queue |
| tx_clear | input | 1 | Empties the outgoing queue |
| rx_clear | input | 1 | Empties the incoming queue |
| src_rx_en | input | 3 | Incoming-condition enable per request source |
| src_tx_en | input | 3 | Outgoing-condition enable per request source |
| irq_rx_thr | input | 4 | Interrupt incoming threshold |
| irq_tx_thr | input | 4 | Interrupt outgoing threshold |
| dma1_rx_thr | input | 5 | DMA request 1 incoming threshold |
| dma1_tx_thr | input | 5 | DMA request 1 outgoing threshold |
| dma2_rx_thr | input | 5 | DMA request 2 incoming threshold |
| dma2_tx_thr | input | 5 | DMA request 2 outgoing threshold |
| status | output | 32 | Packed requests and fill levels |
| irq_req | output | 1 | Interrupt request |
| dma1_req | output | 1 | DMA request 1 |
| dma2_req | output | 1 | DMA request 2 |

## Verification
The queue assertions assume that the read and write strobes are plain single-cycle levels sampled at the clock edge. They also assume that a clear is not treated as data motion, so they check overflow and underflow only in cycles where no clear is active. The stimulus keeps each strobe to one cycle, drives it between edges, and deliberately overfills and overdrains each queue so that the ignore rules are exercised. The request checks assume thresholds are held steady while levels move, so the bench changes thresholds and enables only between transfers.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int SAMPLE_W   = 32;
  localparam int QUEUE_DEPTH = 8;
  localparam int STAT_LVL_W = 5;
  localparam int IRQ_THR_W  = 4;
  localparam int DMA_THR_W  = 5;
  localparam int NUM_SRC    = 3;
  localparam int RX_LVL_LSB = 8;
  localparam int TX_LVL_LSB = 16;
endpackage

// File: rtl/afq_rst_sync.sv
module afq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/afq_fifo.sv
module afq_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [LVL_W-1:0]  level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    rd_d   = rd_q;
    if (clr) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (push_ok) wptr_d = ptr_inc(wptr_q);
      if (pop_ok) begin
        rptr_d = ptr_inc(rptr_q);
        rd_d   = mem[rptr_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
      rd_q   <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  assign pop_data = rd_q;
  assign level    = lvl_q;

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (lvl_q == LVL_W'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !clr) |=> ($stable(rd_q) && lvl_q == '0));
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lvl_q == '0));
endmodule

// File: rtl/afq_req.sv
module afq_req #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_rx,
  input  logic             en_tx,
  input  logic [LVL_W-1:0] thr_rx,
  input  logic [LVL_W-1:0] thr_tx,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  output logic             req
);
  logic rx_hit, tx_hit;

  always_comb begin
    rx_hit = en_rx && (rx_level >= thr_rx);
    tx_hit = en_tx && (tx_level <= thr_tx);
    req    = rx_hit || tx_hit;
  end

  assert_idle_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_rx && !en_tx) |-> !req);
  assert_empty_tx_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_tx && tx_level == '0) |-> req);
endmodule

// File: rtl/audio_req_fifo.sv
module audio_req_fifo
  import audio_fifo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_tx_push,
  input  logic [SAMPLE_W-1:0]  bus_tx_data,
  input  logic                 ser_tx_pop,
  output logic [SAMPLE_W-1:0]  ser_tx_data,
  input  logic                 ser_rx_push,
  input  logic [SAMPLE_W-1:0]  ser_rx_data,
  input  logic                 bus_rx_pop,
  output logic [SAMPLE_W-1:0]  bus_rx_data,
  input  logic                 tx_clear,
  input  logic                 rx_clear,
  input  logic [NUM_SRC-1:0]   src_rx_en,
  input  logic [NUM_SRC-1:0]   src_tx_en,
  input  logic [IRQ_THR_W-1:0] irq_rx_thr,
  input  logic [IRQ_THR_W-1:0] irq_tx_thr,
  input  logic [DMA_THR_W-1:0] dma1_rx_thr,
  input  logic [DMA_THR_W-1:0] dma1_tx_thr,
  input  logic [DMA_THR_W-1:0] dma2_rx_thr,
  input  logic [DMA_THR_W-1:0] dma2_tx_thr,
  output logic [31:0]          status,
  output logic                 irq_req,
  output logic                 dma1_req,
  output logic                 dma2_req
);
  localparam int LVL_W = $clog2(QUEUE_DEPTH + 1);

  logic                  rst_n_s;
  logic [LVL_W-1:0]      tx_lvl, rx_lvl;
  logic [STAT_LVL_W-1:0] tx_lvl_x, rx_lvl_x;
  logic [STAT_LVL_W-1:0] rx_thr_a [NUM_SRC];
  logic [STAT_LVL_W-1:0] tx_thr_a [NUM_SRC];
  logic [NUM_SRC-1:0]    req_v;

  afq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  afq_fifo #(.DATA_W(SAMPLE_W), .DEPTH(QUEUE_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n_s), .clr(tx_clear),
    .push(bus_tx_push), .push_data(bus_tx_data),
    .pop(ser_tx_pop), .pop_data(ser_tx_data), .level(tx_lvl));

  afq_fifo #(.DATA_W(SAMPLE_W), .DEPTH(QUEUE_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n_s), .clr(rx_clear),
    .push(ser_rx_push), .push_data(ser_rx_data),
    .pop(bus_rx_pop), .pop_data(bus_rx_data), .level(rx_lvl));

  assign tx_lvl_x = STAT_LVL_W'(tx_lvl);
  assign rx_lvl_x = STAT_LVL_W'(rx_lvl);

  // Interrupt thresholds are narrower; zero-extend them to the level width.
  assign rx_thr_a[0] = STAT_LVL_W'(irq_rx_thr);
  assign tx_thr_a[0] = STAT_LVL_W'(irq_tx_thr);
  assign rx_thr_a[1] = dma1_rx_thr;
  assign tx_thr_a[1] = dma1_tx_thr;
  assign rx_thr_a[2] = dma2_rx_thr;
  assign tx_thr_a[2] = dma2_tx_thr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    afq_req #(.LVL_W(STAT_LVL_W)) u_req (
      .clk(clk), .rst_n(rst_n_s),
      .en_rx(src_rx_en[g]), .en_tx(src_tx_en[g]),
      .thr_rx(rx_thr_a[g]), .thr_tx(tx_thr_a[g]),
      .rx_level(rx_lvl_x), .tx_level(tx_lvl_x),
      .req(req_v[g]));
  end

  assign irq_req  = req_v[0];
  assign dma1_req = req_v[1];
  assign dma2_req = req_v[2];

  always_comb begin
    status = '0;
    status[NUM_SRC-1:0] = req_v;
    status[RX_LVL_LSB +: STAT_LVL_W] = rx_lvl_x;
    status[TX_LVL_LSB +: STAT_LVL_W] = tx_lvl_x;
  end
endmodule

// File: tb/audio_req_fifo_bench.sv
module audio_req_fifo_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_tx_push = 0, ser_tx_pop = 0, ser_rx_push = 0, bus_rx_pop = 0;
  logic        tx_clear = 0, rx_clear = 0;
  logic [31:0] bus_tx_data = '0, ser_rx_data = '0;
  logic [31:0] ser_tx_data, bus_rx_data, status;
  logic [2:0]  src_rx_en = '0, src_tx_en = '0;
  logic [3:0]  irq_rx_thr = '0, irq_tx_thr = '0;
  logic [4:0]  dma1_rx_thr = '0, dma1_tx_thr = '0, dma2_rx_thr = '0, dma2_tx_thr = '0;
  logic        irq_req, dma1_req, dma2_req;

  int total = 0, bad = 0;
  logic [31:0] tx_q[$], rx_q[$];
  logic [31:0] tx_last = '0, rx_last = '0, tx_exp, rx_exp;
  bit tx_chk = 0, rx_chk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_req_fifo u_audio_req_fifo (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic req_of(int i, int rxl, int txl);
    int rt, tt;
    case (i)
      0: begin rt = irq_rx_thr;  tt = irq_tx_thr;  end
      1: begin rt = dma1_rx_thr; tt = dma1_tx_thr; end
      default: begin rt = dma2_rx_thr; tt = dma2_tx_thr; end
    endcase
    return (src_rx_en[i] && rxl >= rt) || (src_tx_en[i] && txl <= tt);
  endfunction

  task automatic check_status(string tag);
    logic [31:0] e;
    int rl = rx_q.size();
    int tl = tx_q.size();
    e = '0;
    e[0] = req_of(0, rl, tl);
    e[1] = req_of(1, rl, tl);
    e[2] = req_of(2, rl, tl);
    e[12:8]  = rl[4:0];
    e[20:16] = tl[4:0];
    check({tag, " status"}, status, e);
    check({tag, " req pins R8"}, {29'b0, dma2_req, dma1_req, irq_req}, {29'b0, e[2:0]});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tx_push(logic [31:0] d);
    bus_tx_push = 1; bus_tx_data = d;
    if (tx_q.size() < 8) tx_q.push_back(d);
    tick();
    bus_tx_push = 0;
  endtask

  task automatic rx_push(logic [31:0] d);
    ser_rx_push = 1; ser_rx_data = d;
    if (rx_q.size() < 8) rx_q.push_back(d);
    tick();
    ser_rx_push = 0;
  endtask

  task automatic tx_pop();
    ser_tx_pop = 1; tick(); ser_tx_pop = 0;
  endtask

  task automatic rx_pop();
    bus_rx_pop = 1; tick(); bus_rx_pop = 0;
  endtask

  // Monitor: takes the expected word at the edge, compares once the register has loaded (R1, R11).
  always @(posedge clk) begin
    if (rst_n && ser_tx_pop) begin
      if (tx_q.size() > 0) tx_last = tx_q.pop_front();
      tx_exp = tx_last; tx_chk = 1;
    end
    if (rst_n && bus_rx_pop) begin
      if (rx_q.size() > 0) rx_last = rx_q.pop_front();
      rx_exp = rx_last; rx_chk = 1;
    end
  end

  always @(negedge clk) begin
    if (tx_chk) begin check("R1 R11 tx read data", ser_tx_data, tx_exp); tx_chk = 0; end
    if (rx_chk) begin check("R1 R11 rx read data", bus_rx_data, rx_exp); rx_chk = 0; end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R2 reset status", status, 32'h0);
    check_status("R2 reset");

    // Outgoing queue: fill, overfill, drain, overdrain
    for (int i = 0; i < 8; i++) begin
      tx_push(32'hA500_0000 + i);
      check_status("R1 R2 tx fill");
    end
    tx_push(32'hDEAD_BEEF);
    check_status("R3 tx push when full");
    for (int i = 0; i < 8; i++) begin
      tx_pop();
      check_status("R1 tx drain");
    end
    tx_pop();
    check_status("R4 tx pop when empty");
    check("R4 tx data holds", ser_tx_data, 32'hA500_0007);

    // Incoming queue
    for (int i = 0; i < 9; i++) begin
      rx_push(32'h5A00_0100 + i);
      check_status("R1 R3 rx fill");
    end
    for (int i = 0; i < 9; i++) begin
      rx_pop();
      check_status("R4 rx drain");
    end
    check("R4 rx data holds", bus_rx_data, 32'h5A00_0107);

    // R5: DMA1 incoming threshold 3
    src_rx_en = 3'b010; dma1_rx_thr = 5'd3;
    @(negedge clk);
    check_status("R5 rx thr level0");
    for (int i = 0; i < 5; i++) begin
      rx_push(32'h1111_0000 + i);
      check_status("R5 rx thr sweep");
    end
    check("R5 dma1 at level 5", {31'b0, dma1_req}, 32'd1);

    // R6: interrupt outgoing threshold 2
    src_rx_en = 3'b000; src_tx_en = 3'b001; irq_tx_thr = 4'd2;
    @(negedge clk);
    check_status("R6 tx thr level0");
    for (int i = 0; i < 4; i++) begin
      tx_push(32'h2222_0000 + i);
      check_status("R6 tx thr sweep");
    end
    check("R6 irq at tx level 4", {31'b0, irq_req}, 32'd0);

    // R9: interrupt threshold uses 4 bits, DMA uses 5 bits
    src_tx_en = 3'b000; src_rx_en = 3'b101;
    irq_rx_thr = 4'd15; dma2_rx_thr = 5'd16;
    @(negedge clk);
    check_status("R9 wide thresholds");
    check("R9 dma2 thr 16 unreachable", {31'b0, dma2_req}, 32'd0);

    // R7: OR of both conditions on DMA2, then both enables cleared
    src_rx_en = 3'b100; src_tx_en = 3'b100; dma2_rx_thr = 5'd9; dma2_tx_thr = 5'd4;
    @(negedge clk);
    check_status("R7 or tx only");
    dma2_tx_thr = 5'd1; dma2_rx_thr = 5'd5;
    @(negedge clk);
    check_status("R7 or rx only");
    dma2_rx_thr = 5'd9;
    @(negedge clk);
    check_status("R7 neither");
    src_rx_en = 3'b000; src_tx_en = 3'b000; dma2_rx_thr = 5'd0; dma2_tx_thr = 5'd31;
    @(negedge clk);
    check_status("R7 disabled");
    check("R7 all requests low", {29'b0, dma2_req, dma1_req, irq_req}, 32'd0);

    // R10: incoming clear with simultaneous write; outgoing queue untouched
    rx_clear = 1; ser_rx_push = 1; ser_rx_data = 32'h7777_7777;
    rx_q.delete();
    tick();
    rx_clear = 0; ser_rx_push = 0;
    check_status("R10 rx clear wins");
    tx_clear = 1; bus_tx_push = 1; bus_tx_data = 32'h8888_8888;
    tx_q.delete();
    tick();
    tx_clear = 0; bus_tx_push = 0;
    check_status("R10 tx clear wins");
    rx_pop();
    check_status("R10 rx empty after clear");
    rx_push(32'hCAFE_0001);
    rx_pop();
    check_status("R10 rx reuse after clear");

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule